// File: doc/BRIEF.md
# External Interrupt Level Qualifier

This block accepts a priority-encoded interrupt request from a small group of active-low input pins and turns it into a clean, qualified request level plus a set of per-level pending flags for a downstream interrupt controller. The raw pin code is inverted into a level number and passed through a flip-flop synchronizer. A level is accepted only after the synchronized value has held still for two consecutive cycles, so a one-cycle disturbance on the pins never reaches the outputs.

For every nonzero level there is one pending flag. A flag is set when its level is accepted. Raising the request to a more urgent level keeps the flags that are already set. Lowering the request clears every flag above the new level. The controller signals a finished acknowledge cycle with a strobe and the level it served. If that level is pending but is no longer the level the pins are driving, the stale flag is dropped.

Top module: `ext_irq_level_qualifier`

## Requirements
- R1: The pins are active low. The request level is the bitwise inverse of the 3-bit pin code, so all ones on the pins is level 0, which means no request.
- R2: `pending_lvl` has seven bits. Bit i stands for level i+1, so bit 0 is level 1 and bit 6 is level 7.
- R3: A new pin code that is held steady appears on `qual_level` and `pending_lvl` after the fourth rising clock edge at which it is sampled, and not after the third. The delay is made up of two synchronizer stages and a two-cycle stability check.
- R4: A pin code that lasts only one clock cycle before the previous code returns leaves `qual_level` and `pending_lvl` unchanged.
- R5: When a level is accepted that is equal to or higher than the current qualified level, its flag is set and every flag already set is kept. Only the flag of the accepted level is ever newly set.
- R6: When a lower level is accepted, every flag above it is cleared and the flag of the new level is set. Accepting level 0 clears all flags.
- R7: An acknowledge strobe with a nonzero level that differs from `qual_level` clears that level's flag one edge later. An acknowledge for the current qualified level, or for level 0, has no effect.
- R8: When an acknowledge clear and an accepted level change fall on the same edge, both take effect. A set of the accepted level wins over a clear of that same level.
- R9: During reset `qual_level` is 0, all flags are clear and the synchronizer holds level 0.
- R10: While `qual_level` is nonzero its own flag is set, and no flag above `qual_level` is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_pins_n | input | 3 | Raw active-low priority code from the pins, asynchronous to clk |
| ack_done | input | 1 | One-cycle strobe marking the end of an acknowledge cycle |
| ack_level | input | 3 | Level served by the finishing acknowledge cycle |
| pending_lvl | output | 7 | Pending flags, bit i for level i+1 |
| qual_level | output | 3 | Currently qualified request level |

## Verification
An acknowledge clear and a level acceptance can both land on the same clock edge. They meet in the pending flags. The bench makes this happen by first building two pending levels. It then moves the pins so that acceptance lands on a known edge, and raises the acknowledge strobe for exactly that edge. Three cases are covered: a drop together with an acknowledge of the new level, a rise together with an acknowledge of a stale lower level, and a rise together with an acknowledge of the level being left. The expected flags are computed by applying the clear first and then the set.

// File: rtl/irq_qual_pkg.sv
// Package: shared defaults for the external interrupt level qualifier.
// Assumes: level codes are unsigned binary, level 0 means no request.
package irq_qual_pkg;
    localparam int unsigned DEF_LVL_W       = 3;
    localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/irq_pin_sync.sv
// Module: irq_pin_sync
// Inverts the active-low pin code into a level number and carries it
// through a chain of flip-flops into the clk domain.
// Assumes: the pin code changes slowly relative to clk; multi-bit skew
// is tolerated because the downstream filter requires two equal samples.
module irq_pin_sync #(
    parameter int unsigned LVL_W  = irq_qual_pkg::DEF_LVL_W,
    parameter int unsigned STAGES = irq_qual_pkg::DEF_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] pins_n,
    output logic [LVL_W-1:0] sync_lvl
);
    logic [LVL_W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the inverted pin code.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= ~pins_n;
                end
            end else begin : g_next
                // Shift the level one stage further along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_lvl = stage_q[STAGES-1];
endmodule

// File: rtl/irq_level_filter.sv
// Module: irq_level_filter
// Accepts a synchronized level only when two consecutive samples agree,
// and holds the accepted level. The strobe stays high for as long as the
// input is steady, so an accepted level is re-applied every cycle.
// Assumes: sync_lvl is already in the clk domain.
module irq_level_filter #(
    parameter int unsigned LVL_W = irq_qual_pkg::DEF_LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] sync_lvl,
    output logic             qual_stb,
    output logic [LVL_W-1:0] cand_lvl,
    output logic [LVL_W-1:0] qual_level
);
    logic [LVL_W-1:0] prev_q;
    logic [LVL_W-1:0] qual_q;

    // Keep the previous synchronized sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_lvl;
    end

    assign qual_stb = (sync_lvl == prev_q);
    assign cand_lvl = sync_lvl;

    // Latch the candidate as the qualified level once it is steady.
    always_ff @(posedge clk) begin
        if (!rst_n)        qual_q <= '0;
        else if (qual_stb) qual_q <= sync_lvl;
    end

    assign qual_level = qual_q;
endmodule

// File: rtl/irq_pending_bank.sv
// Module: irq_pending_bank
// One pending flag per nonzero level. Each flag is set when its level is
// accepted, dropped when a lower level is accepted, and dropped when an
// acknowledge names it while the pins drive some other level.
// Assumes: qual_stb/cand_lvl come from the filter and qual_level is the
// level held before this edge.
module irq_pending_bank #(
    parameter int unsigned LVL_W   = irq_qual_pkg::DEF_LVL_W,
    localparam int unsigned NUM_LVL = (1 << LVL_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               qual_stb,
    input  logic [LVL_W-1:0]   cand_lvl,
    input  logic [LVL_W-1:0]   qual_level,
    input  logic               ack_done,
    input  logic [LVL_W-1:0]   ack_level,
    output logic [NUM_LVL-1:0] pending
);
    logic [NUM_LVL-1:0] pend_q;
    logic [NUM_LVL-1:0] pend_nxt;
    logic               ack_fire;
    logic               drop_evt;

    // An acknowledge matters only for a nonzero level the pins left.
    assign ack_fire = ack_done && (ack_level != '0) && (ack_level != qual_level);
    // A steady candidate below the held level is a drop in priority.
    assign drop_evt = qual_stb && (cand_lvl < qual_level);

    genvar g;
    generate
        for (g = 0; g < NUM_LVL; g++) begin : g_flag
            localparam logic [LVL_W-1:0] LVL = LVL_W'(g + 1);
            logic clr_ack, clr_drop, set_new;
            // Work out the next state of this level's flag; set wins.
            always_comb begin
                clr_ack     = ack_fire && (ack_level == LVL);
                clr_drop    = drop_evt && (LVL > cand_lvl);
                set_new     = qual_stb && (cand_lvl == LVL);
                pend_nxt[g] = set_new || (pend_q[g] && !clr_ack && !clr_drop);
            end
        end
    endgenerate

    // Register the pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_nxt;
    end

    assign pending = pend_q;
endmodule

// File: rtl/ext_irq_level_qualifier.sv
// Module: ext_irq_level_qualifier (top)
// Synchronizes an active-low priority code, qualifies it over two equal
// samples and keeps per-level pending flags for an interrupt controller.
// Assumes: ack_done is a one-cycle strobe in the clk domain.
module ext_irq_level_qualifier #(
    parameter int unsigned LVL_W       = irq_qual_pkg::DEF_LVL_W,
    parameter int unsigned SYNC_STAGES = irq_qual_pkg::DEF_SYNC_STAGES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LVL_W-1:0]          irq_pins_n,
    input  logic                      ack_done,
    input  logic [LVL_W-1:0]          ack_level,
    output logic [(2**LVL_W)-2:0]     pending_lvl,
    output logic [LVL_W-1:0]          qual_level
);
    logic [LVL_W-1:0] sync_lvl;
    logic             qual_stb;
    logic [LVL_W-1:0] cand_lvl;

    irq_pin_sync #(.LVL_W(LVL_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_n   (irq_pins_n),
        .sync_lvl (sync_lvl)
    );

    irq_level_filter #(.LVL_W(LVL_W)) filt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_lvl   (sync_lvl),
        .qual_stb   (qual_stb),
        .cand_lvl   (cand_lvl),
        .qual_level (qual_level)
    );

    irq_pending_bank #(.LVL_W(LVL_W)) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .qual_stb   (qual_stb),
        .cand_lvl   (cand_lvl),
        .qual_level (qual_level),
        .ack_done   (ack_done),
        .ack_level  (ack_level),
        .pending    (pending_lvl)
    );
endmodule

// File: rtl/irq_qual_checker.sv
// Module: irq_qual_checker
// Property checks for ext_irq_level_qualifier, attached by bind.
// Assumes: the bench holds rst_n low from time zero.
module irq_qual_checker #(
    parameter int unsigned LVL_W   = irq_qual_pkg::DEF_LVL_W,
    localparam int unsigned NUM_LVL = (1 << LVL_W) - 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_done,
    input logic [LVL_W-1:0]   ack_level,
    input logic               qual_stb,
    input logic [LVL_W-1:0]   cand_lvl,
    input logic [LVL_W-1:0]   qual_level,
    input logic [NUM_LVL-1:0] pending
);
    function automatic logic [NUM_LVL-1:0] lvl_bit(input logic [LVL_W-1:0] l);
        lvl_bit = '0;
        for (int i = 0; i < NUM_LVL; i++)
            if (l == LVL_W'(i + 1)) lvl_bit[i] = 1'b1;
    endfunction

    function automatic logic [NUM_LVL-1:0] upto(input logic [LVL_W-1:0] l);
        upto = '0;
        for (int i = 0; i < NUM_LVL; i++)
            if (LVL_W'(i + 1) <= l) upto[i] = 1'b1;
    endfunction

    // R9: reset empties flags and level
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (pending == '0 && qual_level == '0));

    // R10: the qualified level's own flag is set
    p_qual_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_level != '0) |-> ((pending & lvl_bit(qual_level)) != '0));

    // R6: nothing above the qualified level stays pending
    p_none_above_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pending & ~upto(qual_level)) == '0);

    // R5: a rise keeps what was pending
    p_rise_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_stb && cand_lvl >= qual_level && !ack_done)
        |=> ((pending & $past(pending)) == $past(pending)));

    // R5: only the qualified level's flag is ever newly set
    p_only_qual_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pending & ~$past(pending)) & ~lvl_bit(qual_level)) == '0);

    // R7: stale acknowledge clears its flag
    p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && ack_level != '0 && ack_level != qual_level
         && !(qual_stb && cand_lvl == ack_level))
        |=> ((pending & lvl_bit($past(ack_level))) == '0));

    // R7: acknowledge of the driven level changes nothing
    p_ack_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && ack_level == qual_level && !qual_stb) |=> $stable(pending));
endmodule

bind ext_irq_level_qualifier irq_qual_checker #(.LVL_W(LVL_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_done   (ack_done),
    .ack_level  (ack_level),
    .qual_stb   (qual_stb),
    .cand_lvl   (cand_lvl),
    .qual_level (qual_level),
    .pending    (pending_lvl)
);

// File: tb/ext_irq_level_qualifier_tb_top.sv
// Bench: sweeps all level pairs, stale acknowledges and one-cycle glitches,
// plus acknowledge/qualification collisions. Inputs change on falling edges.
module ext_irq_level_qualifier_tb_top;
    localparam int W = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] irq_pins_n = '1;
    logic         ack_done = 1'b0;
    logic [W-1:0] ack_level = '0;
    logic [6:0]   pending_lvl;
    logic [W-1:0] qual_level;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    ext_irq_level_qualifier dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pins_n  (irq_pins_n),
        .ack_done    (ack_done),
        .ack_level   (ack_level),
        .pending_lvl (pending_lvl),
        .qual_level  (qual_level)
    );

    // R2: bit i of the flags stands for level i+1
    function automatic int bit_of(input int l);
        return (l == 0) ? 0 : (1 << (l - 1));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: pins carry the inverted level
    task automatic drive(input int l);
        irq_pins_n = ~W'(l);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; drive(0); ack_done = 1'b0; ack_level = '0;
        cyc(3);
        rst_n = 1'b1;
    endtask

    task automatic settle(input int l);
        drive(l); cyc(6);
    endtask

    initial begin
        cyc(2);
        // R9: outputs during reset
        chk("R9 reset flags", int'(pending_lvl), 0);
        chk("R9 reset level", int'(qual_level), 0);

        // R3 R5 R6: every pair of levels
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                int pa, exp;
                do_reset;
                settle(a);
                pa = bit_of(a);
                chk("R1 R5 first level", int'(qual_level), a);
                chk("R5 first flag", int'(pending_lvl), pa);
                drive(b);
                cyc(3);
                if (a != b) chk("R3 not yet after three edges", int'(qual_level), a);
                cyc(1);
                if (b >= a) exp = pa | bit_of(b);
                else        exp = (pa & ((1 << b) - 1)) | bit_of(b);
                chk("R3 level after four edges", int'(qual_level), b);
                chk(b >= a ? "R5 rise keeps flags" : "R6 drop clears above", int'(pending_lvl), exp);
            end
        end

        // R7: acknowledges with two pending levels
        for (int a = 2; a < 8; a++) begin
            for (int b = 1; b < a; b++) begin
                for (int l = 0; l < 8; l++) begin
                    int base, exp;
                    do_reset;
                    settle(b);
                    settle(a);
                    base = bit_of(a) | bit_of(b);
                    ack_done = 1'b1; ack_level = W'(l);
                    cyc(1);
                    ack_done = 1'b0; ack_level = '0;
                    exp = (l != 0 && l != a) ? (base & ~bit_of(l)) : base;
                    chk("R7 acknowledge", int'(pending_lvl), exp);
                    chk("R7 level kept", int'(qual_level), a);
                end
            end
        end

        // R4: one-cycle glitch to every other code
        for (int a = 0; a < 8; a++) begin
            for (int g = 0; g < 8; g++) begin
                bit bad;
                if (g == a) continue;
                do_reset;
                settle(a);
                drive(g); cyc(1); drive(a);
                bad = 1'b0;
                for (int k = 0; k < 7; k++) begin
                    cyc(1);
                    if (int'(qual_level) != a || int'(pending_lvl) != bit_of(a)) bad = 1'b1;
                end
                chk("R4 glitch ignored", int'(bad), 0);
            end
        end

        // R8: ack on the same edge as qualification
        // drop 4->2 with ack of 2: clear then set, flags {2}
        do_reset; settle(2); settle(4);
        drive(2); cyc(3);
        ack_done = 1'b1; ack_level = 3'd2; cyc(1); ack_done = 1'b0;
        chk("R8 drop with ack of new level", int'(pending_lvl), bit_of(2));
        chk("R8 level after drop", int'(qual_level), 2);
        // rise 4->6 with ack of 2: flags {4,6}
        do_reset; settle(2); settle(4);
        drive(6); cyc(3);
        ack_done = 1'b1; ack_level = 3'd2; cyc(1); ack_done = 1'b0;
        chk("R8 rise with stale ack", int'(pending_lvl), bit_of(4) | bit_of(6));
        // rise 4->6 with ack of 4 (still driven at that edge): {2,4,6}
        do_reset; settle(2); settle(4);
        drive(6); cyc(3);
        ack_done = 1'b1; ack_level = 3'd4; cyc(1); ack_done = 1'b0;
        chk("R8 rise with ack of held level", int'(pending_lvl),
            bit_of(2) | bit_of(4) | bit_of(6));
        // R10: flag of qualified level present
        chk("R10 own flag", int'(pending_lvl) & bit_of(int'(qual_level)), bit_of(6));

        // R9: reset clears a loaded state
        rst_n = 1'b0; cyc(1);
        chk("R9 reset after load", int'(pending_lvl), 0);
        chk("R9 level after load", int'(qual_level), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule